// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a shared memory that two agents, called left and right, reach through two independent ports in a single clock domain. Each port has an active-low enable, a read/write select, an active-low output enable, an active-low hold input that blocks writes, an address, a write-data bus, a read-data bus and a read-valid flag. The read-valid flag takes the place of a tristate bus. With the default parameters the memory holds 2048 words of 8 bits.

The two highest addresses also serve as mailboxes between the agents. The left agent signals the right one by writing the top address, and the right agent signals the left one by writing the address just below it. Each write pulls the receiving side's active-low interrupt line low. The receiver clears that interrupt by reading the same mailbox word. The mailbox data is stored like any other word, so the message travels with the interrupt.

Two small state machines control each port's output path. OUT_HIZ means nothing is driven, and OUT_DRIVE means a read result is presented. The transition FETCH goes into OUT_DRIVE and RELEASE goes back to OUT_HIZ. Each interrupt has its own flag machine with the states FLAG_QUIET and FLAG_RAISED. Its transitions are RAISE (a valid mailbox write by the sender), ACK (a mailbox read by the receiver while no RAISE is pending) and HOLD (no event).

Top module: `dpram_mailbox`

## Requirements
- R1: After reset both interrupt outputs are high, both read-valid outputs are low and both read-data buses are zero. Memory contents are not initialised.
- R2: When a port's enable is high, that port neither stores data nor produces a read result, whatever its other inputs are.
- R3: With enable low, read/write select low (0 means write) and hold high, the write data is stored at the address at the clock edge.
- R4: With enable low, select high and output enable low, the word at the address appears on the read-data bus in the next cycle with read-valid high. If output enable is high, read-valid stays low.
- R5: The read-data bus is zero in every cycle in which read-valid is low.
- R6: A valid left write to the top address (all address bits one) drives the right interrupt low from the next cycle.
- R7: A right read of the top address with enable and output enable low returns the right interrupt high in the next cycle. The same access with output enable high leaves the interrupt unchanged.
- R8: A valid right write to the address one below the top (all ones except bit 0) drives the left interrupt low from the next cycle.
- R9: A left read of the address one below the top with enable and output enable low returns the left interrupt high in the next cycle.
- R10: While a port's hold input is low, its write is not stored and raises no interrupt.
- R11: When a raise and a clear of the same interrupt fall in one cycle, the interrupt ends low.
- R12: If both ports write the same address in one cycle, the right port's data is kept. A read of an address that the other port writes in the same cycle returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_en_n | input | 1 | Left enable, active low |
| lt_rd_wr | input | 1 | Left select, 1 read, 0 write |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_hold_n | input | 1 | Left write hold, active low |
| lt_addr | input | ADDR_W | Left address |
| lt_din | input | DATA_W | Left write data |
| lt_dout | output | DATA_W | Left read data |
| lt_dvalid | output | 1 | Left read data valid |
| lt_irq_n | output | 1 | Interrupt to left, active low |
| rt_en_n | input | 1 | Right enable, active low |
| rt_rd_wr | input | 1 | Right select, 1 read, 0 write |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_hold_n | input | 1 | Right write hold, active low |
| rt_addr | input | ADDR_W | Right address |
| rt_din | input | DATA_W | Right write data |
| rt_dout | output | DATA_W | Right read data |
| rt_dvalid | output | 1 | Right read data valid |
| rt_irq_n | output | 1 | Interrupt to right, active low |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=8, which gives a 16-word memory. With so few words, random addresses hit the two mailbox words about one access in eight. That rate brings simultaneous raise/clear cycles, held mailbox writes and same-address collisions within reach of random stimulus. The mailbox decode is derived from the address width, so the same top and top-minus-one logic is exercised at the default size.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic {
        OUT_HIZ   = 1'b0,
        OUT_DRIVE = 1'b1
    } out_state_e;

    typedef enum logic {
        FLAG_QUIET  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    localparam int PORTS  = 2;
    localparam int P_LEFT = 0;
    localparam int P_RIGHT = 1;

endpackage

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl #(
    parameter int ADDR_W = 11
) (
    input  logic              en_n,
    input  logic              rd_wr,
    input  logic              oe_n,
    input  logic              hold_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_go,
    output logic              rd_go,
    output logic              at_top,
    output logic              at_below
);
    localparam logic [ADDR_W-1:0] TOP_ADDR   = '1;
    localparam logic [ADDR_W-1:0] BELOW_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};

    always_comb begin
        wr_go    = !en_n && !rd_wr && hold_n;
        rd_go    = !en_n && rd_wr && !oe_n;
        at_top   = (addr == TOP_ADDR);
        at_below = (addr == BELOW_ADDR);
    end
endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic [1:0]                    wr_go,
    input  logic [1:0]                    rd_go,
    input  logic [1:0][ADDR_W-1:0]        addr,
    input  logic [1:0][DATA_W-1:0]        din,
    output logic [1:0][DATA_W-1:0]        q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Right port is applied last so it keeps a same-address collision.
    always_ff @(posedge clk) begin
        if (wr_go[0]) store[addr[0]] <= din[0];
        if (wr_go[1]) store[addr[1]] <= din[1];
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rd_go[p]) q[p] <= store[addr[p]];
        end
    end
endmodule

// File: rtl/dpram_out_fsm.sv
module dpram_out_fsm
    import dpram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);
    out_state_e state, state_nx;

    always_comb begin
        unique case (state)
            OUT_HIZ:   state_nx = rd_go ? OUT_DRIVE : OUT_HIZ;   // FETCH
            OUT_DRIVE: state_nx = rd_go ? OUT_DRIVE : OUT_HIZ;   // RELEASE
            default:   state_nx = OUT_HIZ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OUT_HIZ;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            OUT_DRIVE: begin dvalid = 1'b1; dout = q;  end
            default:   begin dvalid = 1'b0; dout = '0; end
        endcase
    end
endmodule

// File: rtl/dpram_flag_fsm.sv
module dpram_flag_fsm
    import dpram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq_n
);
    flag_state_e state, state_nx;

    always_comb begin
        unique case (state)
            FLAG_QUIET:  state_nx = raise ? FLAG_RAISED : FLAG_QUIET;            // RAISE / HOLD
            FLAG_RAISED: state_nx = (ack && !raise) ? FLAG_QUIET : FLAG_RAISED;   // ACK / HOLD
            default:     state_nx = FLAG_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLAG_QUIET;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            FLAG_RAISED: irq_n = 1'b0;
            default:     irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_en_n,
    input  logic              lt_rd_wr,
    input  logic              lt_oe_n,
    input  logic              lt_hold_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_din,
    output logic [DATA_W-1:0] lt_dout,
    output logic              lt_dvalid,
    output logic              lt_irq_n,
    input  logic              rt_en_n,
    input  logic              rt_rd_wr,
    input  logic              rt_oe_n,
    input  logic              rt_hold_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_din,
    output logic [DATA_W-1:0] rt_dout,
    output logic              rt_dvalid,
    output logic              rt_irq_n
);
    logic [PORTS-1:0]             en_n_v, rd_wr_v, oe_n_v, hold_n_v;
    logic [PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [PORTS-1:0][DATA_W-1:0] din_v, q_v, dout_v;
    logic [PORTS-1:0]             wr_go_v, rd_go_v, top_v, below_v, dvalid_v;

    always_comb begin
        en_n_v   = {rt_en_n,   lt_en_n};
        rd_wr_v  = {rt_rd_wr,  lt_rd_wr};
        oe_n_v   = {rt_oe_n,   lt_oe_n};
        hold_n_v = {rt_hold_n, lt_hold_n};
        addr_v   = {rt_addr,   lt_addr};
        din_v    = {rt_din,    lt_din};
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        dpram_port_ctl #(.ADDR_W(ADDR_W)) ctl_i (
            .en_n     (en_n_v[p]),
            .rd_wr    (rd_wr_v[p]),
            .oe_n     (oe_n_v[p]),
            .hold_n   (hold_n_v[p]),
            .addr     (addr_v[p]),
            .wr_go    (wr_go_v[p]),
            .rd_go    (rd_go_v[p]),
            .at_top   (top_v[p]),
            .at_below (below_v[p])
        );

        dpram_out_fsm #(.DATA_W(DATA_W)) out_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_go  (rd_go_v[p]),
            .q      (q_v[p]),
            .dout   (dout_v[p]),
            .dvalid (dvalid_v[p])
        );
    end

    dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk   (clk),
        .wr_go (wr_go_v),
        .rd_go (rd_go_v),
        .addr  (addr_v),
        .din   (din_v),
        .q     (q_v)
    );

    // Mailbox toward the right agent: left writes the top word, right reads it.
    dpram_flag_fsm to_right_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (wr_go_v[P_LEFT]  && top_v[P_LEFT]),
        .ack   (rd_go_v[P_RIGHT] && top_v[P_RIGHT]),
        .irq_n (rt_irq_n)
    );

    // Mailbox toward the left agent: right writes the word below the top.
    dpram_flag_fsm to_left_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (wr_go_v[P_RIGHT] && below_v[P_RIGHT]),
        .ack   (rd_go_v[P_LEFT]  && below_v[P_LEFT]),
        .irq_n (lt_irq_n)
    );

    assign lt_dout   = dout_v[P_LEFT];
    assign lt_dvalid = dvalid_v[P_LEFT];
    assign rt_dout   = dout_v[P_RIGHT];
    assign rt_dvalid = dvalid_v[P_RIGHT];
endmodule

// File: rtl/dpram_mailbox_chk.sv
module dpram_mailbox_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lt_en_n,
    input logic              lt_rd_wr,
    input logic              lt_oe_n,
    input logic              lt_hold_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              lt_dvalid,
    input logic              lt_irq_n,
    input logic              rt_en_n,
    input logic              rt_rd_wr,
    input logic              rt_oe_n,
    input logic              rt_hold_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_dvalid,
    input logic              rt_irq_n
);
    localparam logic [ADDR_W-1:0] TOP_A   = '1;
    localparam logic [ADDR_W-1:0] BELOW_A = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic l_wr, r_wr, l_rd, r_rd;
    assign l_wr = !lt_en_n && !lt_rd_wr && lt_hold_n;
    assign r_wr = !rt_en_n && !rt_rd_wr && rt_hold_n;
    assign l_rd = !lt_en_n && lt_rd_wr && !lt_oe_n;
    assign r_rd = !rt_en_n && rt_rd_wr && !rt_oe_n;

    p_idle_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lt_en_n |=> !lt_dvalid);
    p_idle_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rt_en_n |=> !rt_dvalid);
    p_read_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd |=> lt_dvalid);
    p_raise_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wr && lt_addr == TOP_A) |=> !rt_irq_n);
    p_ack_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rd && rt_addr == TOP_A && !(l_wr && lt_addr == TOP_A)) |=> rt_irq_n);
    p_raise_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_wr && rt_addr == BELOW_A) |=> !lt_irq_n);
    p_ack_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rd && lt_addr == BELOW_A && !(r_wr && rt_addr == BELOW_A)) |=> lt_irq_n);
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_irq_n && !(l_wr && lt_addr == TOP_A)) |=> rt_irq_n);
endmodule

bind dpram_mailbox dpram_mailbox_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lt_en_n   (lt_en_n),
    .lt_rd_wr  (lt_rd_wr),
    .lt_oe_n   (lt_oe_n),
    .lt_hold_n (lt_hold_n),
    .lt_addr   (lt_addr),
    .lt_dvalid (lt_dvalid),
    .lt_irq_n  (lt_irq_n),
    .rt_en_n   (rt_en_n),
    .rt_rd_wr  (rt_rd_wr),
    .rt_oe_n   (rt_oe_n),
    .rt_hold_n (rt_hold_n),
    .rt_addr   (rt_addr),
    .rt_dvalid (rt_dvalid),
    .rt_irq_n  (rt_irq_n)
);

// File: tb/dpram_mailbox_tb_top.sv
module dpram_mailbox_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] TOP_A   = '1;
    localparam logic [AW-1:0] BELOW_A = {{(AW-1){1'b1}}, 1'b0};

    logic clk = 1'b0;
    logic rst_n;
    logic lt_en_n, lt_rd_wr, lt_oe_n, lt_hold_n;
    logic rt_en_n, rt_rd_wr, rt_oe_n, rt_hold_n;
    logic [AW-1:0] lt_addr, rt_addr;
    logic [DW-1:0] lt_din, rt_din, lt_dout, rt_dout;
    logic lt_dvalid, rt_dvalid, lt_irq_n, rt_irq_n;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] mem_m [DEPTH];
    logic          e_lt_irq_n, e_rt_irq_n, e_lt_dv, e_rt_dv;
    logic [DW-1:0] e_lt_do, e_rt_do;

    dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lt_en_n(lt_en_n), .lt_rd_wr(lt_rd_wr), .lt_oe_n(lt_oe_n), .lt_hold_n(lt_hold_n),
        .lt_addr(lt_addr), .lt_din(lt_din), .lt_dout(lt_dout), .lt_dvalid(lt_dvalid),
        .lt_irq_n(lt_irq_n),
        .rt_en_n(rt_en_n), .rt_rd_wr(rt_rd_wr), .rt_oe_n(rt_oe_n), .rt_hold_n(rt_hold_n),
        .rt_addr(rt_addr), .rt_din(rt_din), .rt_dout(rt_dout), .rt_dvalid(rt_dvalid),
        .rt_irq_n(rt_irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic does_write(logic en_n, logic rd_wr, logic hold_n);
        return !en_n && !rd_wr && hold_n;
    endfunction

    function automatic logic does_read(logic en_n, logic rd_wr, logic oe_n);
        return !en_n && rd_wr && !oe_n;
    endfunction

    task automatic model_step();
        logic lw, rw, lr, rr;
        lw = does_write(lt_en_n, lt_rd_wr, lt_hold_n);
        rw = does_write(rt_en_n, rt_rd_wr, rt_hold_n);
        lr = does_read(lt_en_n, lt_rd_wr, lt_oe_n);
        rr = does_read(rt_en_n, rt_rd_wr, rt_oe_n);
        e_lt_dv = lr;
        e_rt_dv = rr;
        e_lt_do = lr ? mem_m[lt_addr] : '0;
        e_rt_do = rr ? mem_m[rt_addr] : '0;
        if (lw && lt_addr == TOP_A)        e_rt_irq_n = 1'b0;
        else if (rr && rt_addr == TOP_A)   e_rt_irq_n = 1'b1;
        if (rw && rt_addr == BELOW_A)      e_lt_irq_n = 1'b0;
        else if (lr && lt_addr == BELOW_A) e_lt_irq_n = 1'b1;
        if (lw) mem_m[lt_addr] = lt_din;
        if (rw) mem_m[rt_addr] = rt_din;
    endtask

    task automatic check1(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check1(tag, "lt_dvalid", DW'(lt_dvalid), DW'(e_lt_dv));
        check1(tag, "lt_dout",   lt_dout,        e_lt_do);
        check1(tag, "rt_dvalid", DW'(rt_dvalid), DW'(e_rt_dv));
        check1(tag, "rt_dout",   rt_dout,        e_rt_do);
        check1(tag, "lt_irq_n",  DW'(lt_irq_n),  DW'(e_lt_irq_n));
        check1(tag, "rt_irq_n",  DW'(rt_irq_n),  DW'(e_rt_irq_n));
    endtask

    task automatic tick(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic drv_l(logic en_n, logic rd_wr, logic oe_n, logic hold_n,
                         logic [AW-1:0] a, logic [DW-1:0] d);
        lt_en_n = en_n; lt_rd_wr = rd_wr; lt_oe_n = oe_n; lt_hold_n = hold_n;
        lt_addr = a; lt_din = d;
    endtask

    task automatic drv_r(logic en_n, logic rd_wr, logic oe_n, logic hold_n,
                         logic [AW-1:0] a, logic [DW-1:0] d);
        rt_en_n = en_n; rt_rd_wr = rd_wr; rt_oe_n = oe_n; rt_hold_n = hold_n;
        rt_addr = a; rt_din = d;
    endtask

    task automatic idle_both();
        drv_l(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
        drv_r(1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd715);
        idle_both();
        rst_n = 1'b0;
        e_lt_irq_n = 1'b1; e_rt_irq_n = 1'b1;
        e_lt_dv = 1'b0; e_rt_dv = 1'b0; e_lt_do = '0; e_rt_do = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // Fill every word from the left port (R3); the top word raises right.
        for (int i = 0; i < DEPTH; i++) begin
            drv_l(1'b0, 1'b0, 1'b1, 1'b1, AW'(i), DW'(i * 17 + 3));
            tick("R3");
        end
        idle_both();
        drv_l(1'b0, 1'b0, 1'b1, 1'b1, AW'(3), 8'hA5); tick("R3");
        idle_both();
        drv_r(1'b0, 1'b1, 1'b0, 1'b1, AW'(3), '0);    tick("R4");
        idle_both();                                  tick("R5");

        // R2: disabled write and disabled read do nothing.
        drv_l(1'b1, 1'b0, 1'b0, 1'b1, AW'(3), 8'h00); tick("R2");
        drv_l(1'b1, 1'b1, 1'b0, 1'b1, AW'(3), 8'h00); tick("R2");
        idle_both();
        drv_r(1'b0, 1'b1, 1'b0, 1'b1, AW'(3), '0);    tick("R2");

        // R4: output enable high gives no valid data.
        idle_both();
        drv_l(1'b0, 1'b1, 1'b1, 1'b1, AW'(3), '0);    tick("R4");

        // R7: right interrupt is low after fill; oe high keeps it, oe low clears.
        idle_both();
        drv_r(1'b0, 1'b1, 1'b1, 1'b1, TOP_A, '0);     tick("R7");
        drv_r(1'b0, 1'b1, 1'b0, 1'b1, TOP_A, '0);     tick("R7");
        idle_both();
        drv_l(1'b0, 1'b0, 1'b1, 1'b1, TOP_A, 8'h5C);  tick("R6");
        idle_both();
        drv_r(1'b0, 1'b0, 1'b1, 1'b1, BELOW_A, 8'hC3); tick("R8");
        idle_both();
        drv_l(1'b0, 1'b1, 1'b0, 1'b1, BELOW_A, '0);   tick("R9");
        idle_both();
        drv_r(1'b0, 1'b1, 1'b0, 1'b1, TOP_A, '0);     tick("R7");

        // R10: held writes store nothing and raise nothing.
        idle_both();
        drv_l(1'b0, 1'b0, 1'b1, 1'b0, TOP_A, 8'hEE);   tick("R10");
        drv_r(1'b0, 1'b0, 1'b1, 1'b0, BELOW_A, 8'hDD); tick("R10");
        idle_both();
        drv_r(1'b0, 1'b1, 1'b0, 1'b1, TOP_A, '0);      tick("R10");
        idle_both();
        drv_l(1'b0, 1'b1, 1'b0, 1'b1, BELOW_A, '0);    tick("R10");

        // R11: raise and clear in the same cycle.
        drv_l(1'b0, 1'b0, 1'b1, 1'b1, TOP_A, 8'h11);
        drv_r(1'b0, 1'b1, 1'b0, 1'b1, TOP_A, '0);      tick("R11");
        drv_l(1'b0, 1'b1, 1'b0, 1'b1, BELOW_A, '0);
        drv_r(1'b0, 1'b0, 1'b1, 1'b1, BELOW_A, 8'h22); tick("R11");

        // R12: collisions.
        drv_l(1'b0, 1'b0, 1'b1, 1'b1, AW'(5), 8'h4B);
        drv_r(1'b0, 1'b0, 1'b1, 1'b1, AW'(5), 8'hB4);  tick("R12");
        drv_l(1'b0, 1'b1, 1'b0, 1'b1, AW'(5), '0);
        drv_r(1'b0, 1'b1, 1'b0, 1'b1, AW'(5), '0);     tick("R12");
        drv_l(1'b0, 1'b1, 1'b0, 1'b1, AW'(6), '0);
        drv_r(1'b0, 1'b0, 1'b1, 1'b1, AW'(6), 8'h66);  tick("R12");
        drv_r(1'b1, 1'b1, 1'b1, 1'b1, AW'(6), '0);     tick("R12");

        // Random phase, mixed ops, checked against the model (R5 covers idle zeros).
        for (int n = 0; n < 4000; n++) begin
            drv_l(($urandom % 4) == 0, $urandom % 2, ($urandom % 4) == 0,
                  ($urandom % 5) != 0, AW'($urandom), DW'($urandom));
            drv_r(($urandom % 4) == 0, $urandom % 2, ($urandom % 4) == 0,
                  ($urandom % 5) != 0, AW'($urandom), DW'($urandom));
            tick("R5");
        end

        idle_both();
        tick("R5");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule